// File: doc/BRIEF.md
# Memory-Assisted Four-Bit Calculator

This block is a small arithmetic unit with one result memory, built around a four-bit adder. Two operand words arrive from static inputs, and a four-bit operation code selects what is computed. The low three code bits choose one of eight adder-based operations: add, add with increment, subtract, subtract with decrement, increment, decrement and two forms of pass-through. The unit also produces a carry bit, a signed overflow bit and a zero bit.

A save strobe copies the current result into a single memory register. When the top code bit is set, the stored word takes the place of the second operand. Repeated operations can then chain through the memory, for example to build a running count. The result and all flags are combinational functions of the inputs and the stored word. The memory register is the only clocked state.

Top module: `tinycalc`

## Requirements
- R1: For operation code bits [2:0] = 000 the result is A+Bsel, and for 001 it is A+Bsel+1. In both cases the carry output is bit 4 of the five-bit unsigned sum.
- R2: For code 010 the result is A-Bsel-1, and for 011 it is A-Bsel. Both are formed as A + ~Bsel + cin, and the carry output is the adder carry, which is 1 when no borrow occurs.
- R3: Code 100 gives A with carry 0, code 101 gives A+1, and code 110 gives A-1 as A+1111. Code 111 gives A as A+1111+1, with carry always 1.
- R4: The zero output is 1 exactly when all four result bits are 0.
- R5: The overflow output is 1 exactly when the signed two's-complement sum of A, the adder's second input and the carry-in falls outside -8..7.
- R6: Operation code bit 3 selects the second operand Bsel. A value of 0 takes the switch operand B and ignores the memory. A value of 1 takes the stored memory word and ignores B.
- R7: On the first cycle the save input is 1 after a cycle at 0, the memory register captures the current result. The new value appears on the memory output one clock later.
- R8: While the save input stays high, or stays low, the memory register keeps its value.
- R9: A synchronous reset clears the memory register to 0000.
- R10: Result and flags follow the inputs and the memory within the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sw | input | 4 | Operand A |
| b_sw | input | 4 | Operand B from switches |
| op | input | 4 | Bits [2:0] operation, bit 3 memory-as-B select |
| save_btn | input | 1 | Synchronous save level; rising edge stores result |
| result | output | 4 | Combinational result |
| carry | output | 1 | Adder carry out |
| ovf | output | 1 | Signed overflow |
| zero | output | 1 | Result-is-zero flag |
| mem_val | output | 4 | Stored memory word |

## Verification
A corrupted memory register shows on `mem_val` one clock after the faulty capture. When bit 3 of the code is set, the same fault also reaches `result` and the flags in that cycle, so chained increments quickly diverge from the expected running count. A faulty edge detector shows up as a second capture while the save input is held high. The bench catches this by changing the operand while the button is held and then reading the memory. Datapath faults appear at once on `result` and the flags, and every operation is checked exhaustively over all operand pairs.

// File: rtl/tinycalc_pkg.sv
package tinycalc_pkg;
    localparam int OP_W = 4;

    typedef enum logic [2:0] {
        CALC_ADD    = 3'b000,
        CALC_ADDINC = 3'b001,
        CALC_SUBDEC = 3'b010,
        CALC_SUB    = 3'b011,
        CALC_PASS   = 3'b100,
        CALC_INC    = 3'b101,
        CALC_DEC    = 3'b110,
        CALC_PASSC  = 3'b111
    } calc_fn_e;
endpackage

// File: rtl/tinycalc_opsel.sv
module tinycalc_opsel
    import tinycalc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [2:0]   fn,
    input  logic [W-1:0] bsel,
    output logic [W-1:0] y,
    output logic         cin
);
    always_comb begin
        y   = '0;
        cin = 1'b0;
        case (calc_fn_e'(fn))
            CALC_ADD:    begin y = bsel;   cin = 1'b0; end
            CALC_ADDINC: begin y = bsel;   cin = 1'b1; end
            CALC_SUBDEC: begin y = ~bsel;  cin = 1'b0; end
            CALC_SUB:    begin y = ~bsel;  cin = 1'b1; end
            CALC_PASS:   begin y = '0;     cin = 1'b0; end
            CALC_INC:    begin y = '0;     cin = 1'b1; end
            CALC_DEC:    begin y = '1;     cin = 1'b0; end
            CALC_PASSC:  begin y = '1;     cin = 1'b1; end
            default:     begin y = '0;     cin = 1'b0; end
        endcase
    end
endmodule

// File: rtl/tinycalc_adder.sv
module tinycalc_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout,
    output logic         v
);
    logic [W:0] c;
    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i]   = x[i] ^ y[i] ^ c[i];
        assign c[i+1] = (x[i] & y[i]) | (x[i] & c[i]) | (y[i] & c[i]);
    end

    assign cout = c[W];
    assign v    = c[W] ^ c[W-1];
endmodule

// File: rtl/tinycalc_memreg.sv
module tinycalc_memreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         save,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] word;
        logic         save_prev;
    } mem_state_t;

    mem_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.save_prev = save;
        if (rst) begin
            st_d.word = '0;
        end else if (save && !st_q.save_prev) begin
            st_d.word = din;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.word;
endmodule

// File: rtl/tinycalc.sv
module tinycalc
    import tinycalc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  a_sw,
    input  logic [W-1:0]  b_sw,
    input  logic [OP_W-1:0] op,
    input  logic          save_btn,
    output logic [W-1:0]  result,
    output logic          carry,
    output logic          ovf,
    output logic          zero,
    output logic [W-1:0]  mem_val
);
    logic [W-1:0] bsel;
    logic [W-1:0] y;
    logic         cin;

    assign bsel = op[OP_W-1] ? mem_val : b_sw;

    tinycalc_opsel #(.W(W)) u_opsel (
        .fn   (op[2:0]),
        .bsel (bsel),
        .y    (y),
        .cin  (cin)
    );

    tinycalc_adder #(.W(W)) u_add (
        .x    (a_sw),
        .y    (y),
        .cin  (cin),
        .s    (result),
        .cout (carry),
        .v    (ovf)
    );

    assign zero = ~|result;

    tinycalc_memreg #(.W(W)) u_mem (
        .clk  (clk),
        .rst  (rst),
        .save (save_btn),
        .din  (result),
        .dout (mem_val)
    );
endmodule

// File: rtl/tinycalc_chk.sv
module tinycalc_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_sw,
    input logic [W-1:0] b_sw,
    input logic [3:0]   op,
    input logic         save_btn,
    input logic [W-1:0] result,
    input logic         carry,
    input logic         ovf,
    input logic         zero,
    input logic [W-1:0] mem_val
);
    logic [W-1:0] beff;
    assign beff = op[3] ? mem_val : b_sw;

    // R1
    p_add_r1: assert property (@(posedge clk) disable iff (rst)
        (op[2:0] == 3'b000) |-> ({carry, result} == ({1'b0, a_sw} + {1'b0, beff})));

    // R3
    p_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (op[2:0] == 3'b100) |-> (result == a_sw && !carry && !ovf));

    // R4
    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
        zero == (result == '0));

    // R6
    p_memsub_r6: assert property (@(posedge clk) disable iff (rst)
        (op == 4'b1011) |-> (result == W'(a_sw - mem_val)));

    // R7
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        (save_btn && !$past(save_btn)) |=> (mem_val == $past(result)));

    // R8
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(save_btn && !$past(save_btn)) |=> $stable(mem_val));

    // R9
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (mem_val == '0));
endmodule

bind tinycalc tinycalc_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .a_sw(a_sw), .b_sw(b_sw), .op(op),
    .save_btn(save_btn), .result(result), .carry(carry), .ovf(ovf),
    .zero(zero), .mem_val(mem_val)
);

// File: tb/sim_tinycalc.sv
`timescale 1ns/1ps
module sim_tinycalc;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a_sw = '0, b_sw = '0, op = '0;
    logic       save_btn = 1'b0;
    logic [3:0] result, mem_val;
    logic       carry, ovf, zero;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tinycalc u0 (
        .clk(clk), .rst(rst), .a_sw(a_sw), .b_sw(b_sw), .op(op),
        .save_btn(save_btn), .result(result), .carry(carry), .ovf(ovf),
        .zero(zero), .mem_val(mem_val)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_calc(input logic [3:0] a, input logic [3:0] bb,
                               input logic [2:0] fn, output logic [3:0] r,
                               output logic c, output logic v, output logic z);
        logic [3:0] y;
        logic       ci;
        logic [4:0] sum;
        int sa, sy, ss;
        case (fn)
            3'd0: begin y = bb;      ci = 0; end
            3'd1: begin y = bb;      ci = 1; end
            3'd2: begin y = ~bb;     ci = 0; end
            3'd3: begin y = ~bb;     ci = 1; end
            3'd4: begin y = 4'h0;    ci = 0; end
            3'd5: begin y = 4'h0;    ci = 1; end
            3'd6: begin y = 4'hF;    ci = 0; end
            default: begin y = 4'hF; ci = 1; end
        endcase
        sum = {1'b0, a} + {1'b0, y} + {4'b0, ci};
        r = sum[3:0];
        c = sum[4];
        sa = a[3] ? int'(a) - 16 : int'(a);
        sy = y[3] ? int'(y) - 16 : int'(y);
        ss = sa + sy + int'(ci);
        v = (ss > 7) || (ss < -8);
        z = (r == 4'h0);
    endtask

    task automatic check_outputs(input string tag, input logic [3:0] bb);
        logic [3:0] r;
        logic c, v, z;
        expect_calc(a_sw, bb, op[2:0], r, c, v, z);
        chk({tag, " result"}, int'(result), int'(r));
        chk({tag, " carry"},  int'(carry),  int'(c));
        chk("R5 ovf",         int'(ovf),    int'(v));
        chk("R4 zero",        int'(zero),   int'(z));
    endtask

    task automatic press();
        @(negedge clk) save_btn = 1'b1;
        @(negedge clk) save_btn = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 reset mem", int'(mem_val), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 mem after release", int'(mem_val), 0);
    endtask

    // R1 R2 R3 R10: exhaustive over switch operands, no clock between changes
    task automatic t_ops_switch();
        for (int f = 0; f < 8; f++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    op = {1'b0, 3'(f)}; a_sw = 4'(a); b_sw = 4'(b);
                    #1;
                    if (f < 2)      check_outputs("R1", b_sw);
                    else if (f < 4) check_outputs("R2", b_sw);
                    else            check_outputs("R3", b_sw);
                end
            end
        end
    endtask

    task automatic t_store_and_chain();
        @(negedge clk);
        op = 4'b0000; a_sw = 4'd3; b_sw = 4'd4;
        #1 chk("R10 live result", int'(result), 7);
        press();
        chk("R7 stored 7", int'(mem_val), 7);
        // memory mode: A + mem, A=1 -> running count
        op = 4'b1000; a_sw = 4'd1; b_sw = 4'd9;
        #1 check_outputs("R6", mem_val);
        chk("R6 uses mem", int'(result), 8);
        for (int k = 0; k < 9; k++) press();
        chk("R7 chain value", int'(mem_val), 0);
        #1 chk("R1 wrap carry", int'(carry), 0);
        chk("R4 zero chain", int'(zero), 0);
        op = 4'b1011; a_sw = 4'd0; #1;
        check_outputs("R6 sub mem", mem_val);
        for (int m = 0; m < 16; m++) begin
            op = {1'b1, 3'(m % 8)}; a_sw = 4'(m * 5); #1;
            check_outputs("R6 mem ops", mem_val);
        end
    endtask

    task automatic t_hold();
        op = 4'b0000; a_sw = 4'd2; b_sw = 4'd3;
        @(negedge clk) save_btn = 1'b1;
        @(negedge clk);
        chk("R7 captured", int'(mem_val), 5);
        a_sw = 4'd8;
        repeat (3) @(negedge clk);
        chk("R8 held no reload", int'(mem_val), 5);
        save_btn = 1'b0;
        a_sw = 4'd1;
        repeat (3) @(negedge clk);
        chk("R8 idle no reload", int'(mem_val), 5);
        op = 4'b0000; b_sw = 4'd6; #1;
        chk("R6 switch B ignores mem", int'(result), 7);
    endtask

    task automatic t_reset_again();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        chk("R9 mem cleared", int'(mem_val), 0);
        op = 4'b1000; a_sw = 4'd0; #1;
        chk("R4 zero with mem 0", int'(zero), 1);
    endtask

    initial begin
        t_reset();
        t_ops_switch();
        t_store_and_chain();
        t_hold();
        t_reset_again();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule